// File: doc/BRIEF.md
# Multi-Period Coprocessor Wakeup Timer

This block sequences the sleep and wake cycle of a small coprocessor. While the coprocessor is powered down, the block counts ticks of a slow clock. The slow clock reaches the block as a one-cycle strobe in the fast clock domain. When the count reaches the selected period, the block powers the coprocessor up. It issues a one-cycle go pulse and presents the entry address that was latched at that moment. When the coprocessor reports a halt or an illegal instruction, the block powers it down and counts again from zero.

Five period registers are held inside the block. A launch command starts the cycle with period 0. After that, the running program picks the period that governs each later sleep by issuing a sleep command with a register index. A minimum-sleep value sets a floor on the number of ticks before any wakeup. A timer-enable bit can be cleared to stop periodic wakeups.

Top module: `cop_wake_timer`

## Requirements
- R1: After reset the coprocessor is unpowered, `core_go` is low, `core_entry` is 0 and the timer is disabled, so slow ticks cause no wakeup until `launch`.
- R2: `launch`, when the coprocessor is not powered, enables the timer, selects period register 0 and restarts the tick count from 0.
- R3: A `slp_valid` pulse with `slp_idx` in 0..4 selects the period register for every later sleep; an index of 5 or more is ignored.
- R4: The wakeup happens on the N-th slow tick of a sleep, where N = max(selected period, minimum sleep). `core_pwr` rises and `core_go` is high for exactly one cycle, both in the cycle after that tick is sampled.
- R5: While powered, `core_halt` or `core_illegal` drops `core_pwr` in the next cycle, and the tick count restarts from 0.
- R6: The minimum-sleep value is 8 bits wide (cfg_kind 2, cfg_data[7:0]); a written value below 2 is stored as 2, and the reset value is 2.
- R7: A period write (cfg_kind 0) with `cfg_idx` above 4 is rejected and changes no register.
- R8: Writing 0 to the enable bit (cfg_kind 3, cfg_data[0]) stops all later wakeups until the next `launch`; a halt while disabled leaves the block idle.
- R9: A period value of 0 counts as 1 tick, so the counter never stalls.
- R10: The entry address (cfg_kind 1, cfg_data[10:0]) is copied to `core_entry` only at a wakeup; a write during a run appears only from the next wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target: 0 period, 1 entry, 2 minimum sleep, 3 enable |
| cfg_idx | input | 3 | Period register index for kind 0 |
| cfg_data | input | 24 | Write data |
| launch | input | 1 | Start the timer with period 0 |
| slp_valid | input | 1 | Sleep command from the coprocessor |
| slp_idx | input | 3 | Period register index of the sleep command |
| core_halt | input | 1 | Coprocessor halted |
| core_illegal | input | 1 | Coprocessor hit an illegal instruction |
| core_pwr | output | 1 | Coprocessor power request |
| core_go | output | 1 | One-cycle start pulse at wakeup |
| core_entry | output | 11 | Entry address latched at wakeup |

## Verification
The bench measures the exact tick on which each wakeup lands. It covers periods of 0 and 1 against the floor of 2, a minimum sleep larger than the period, and a long period. An off-by-one in the comparison would wake one tick early or late. A stalled counter for period 0 would never wake, and a missing floor clamp would wake after a single tick. Further cases target the period choice and the entry address. An out-of-range sleep index or period write that leaked through would shift the next wakeup. An entry address that was not latched would change `core_entry` in the middle of a run. Disabling the timer is checked over many idle ticks, because a block that ignores the bit powers the core up again.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_RUN   = 2'd2
  } cwt_state_t;

  typedef enum logic [1:0] {
    WK_PERIOD = 2'd0,
    WK_ENTRY  = 2'd1,
    WK_MINSLP = 2'd2,
    WK_CTRL   = 2'd3
  } cwt_kind_t;
endpackage

// File: rtl/cwt_period_bank.sv
module cwt_period_bank #(
  parameter int N_PER = 5,
  parameter int PER_W = 24,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PER_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PER_W-1:0] rd_eff
);
  logic [PER_W-1:0] per_q [N_PER];
  logic [PER_W-1:0] raw;

  for (genvar i = 0; i < N_PER; i++) begin : g_per
    always_ff @(posedge clk) begin
      if (rst) begin
        per_q[i] <= '0;
      end else if (we && (wr_idx == IDX_W'(i))) begin
        per_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < N_PER; i++) begin
      if (rd_idx == IDX_W'(i)) raw = per_q[i];
    end
    rd_eff = (raw == '0) ? PER_W'(1) : raw;
  end
endmodule

// File: rtl/cwt_tick_counter.sv
module cwt_tick_counter #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             tick,
  input  logic [PER_W-1:0] thr,
  output logic             hit
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + (PER_W+1)'(1);
  assign hit    = cnt_en && tick && (cnt_nx >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cnt_en && tick) begin
      cnt_q <= hit ? '0 : cnt_nx[PER_W-1:0];
    end
  end
endmodule

// File: rtl/cwt_wake_fsm.sv
module cwt_wake_fsm
  import cwt_pkg::*;
#(
  parameter int N_PER = 5,
  parameter int IDX_W = 3,
  parameter int ENT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             en_q,
  input  logic             hit,
  input  logic             stop,
  input  logic             slp_valid,
  input  logic [IDX_W-1:0] slp_idx,
  input  logic [ENT_W-1:0] entry_q,
  output cwt_state_t       state,
  output logic [IDX_W-1:0] sel_q,
  output logic             pwr,
  output logic             go,
  output logic [ENT_W-1:0] entry_out
);
  logic start_ok;
  assign start_ok = launch && (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      pwr       <= 1'b0;
      go        <= 1'b0;
      entry_out <= '0;
    end else begin
      go <= 1'b0;
      if (start_ok) begin
        sel_q <= '0;
      end else if (slp_valid && (slp_idx < IDX_W'(N_PER))) begin
        sel_q <= slp_idx;
      end
      unique case (state)
        ST_IDLE: begin
          if (start_ok) state <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (start_ok) begin
            state <= ST_SLEEP;
          end else if (!en_q) begin
            state <= ST_IDLE;
          end else if (hit) begin
            state     <= ST_RUN;
            pwr       <= 1'b1;
            go        <= 1'b1;
            entry_out <= entry_q;
          end
        end
        ST_RUN: begin
          if (stop) begin
            pwr   <= 1'b0;
            state <= en_q ? ST_SLEEP : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cop_wake_timer.sv
module cop_wake_timer
  import cwt_pkg::*;
#(
  parameter int N_PER     = 5,
  parameter int PER_W     = 24,
  parameter int ENT_W     = 11,
  parameter int MIN_W     = 8,
  parameter int MIN_FLOOR = 2,
  localparam int IDX_W    = $clog2(N_PER)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_tick,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [PER_W-1:0] cfg_data,
  input  logic             launch,
  input  logic             slp_valid,
  input  logic [IDX_W-1:0] slp_idx,
  input  logic             core_halt,
  input  logic             core_illegal,
  output logic             core_pwr,
  output logic             core_go,
  output logic [ENT_W-1:0] core_entry
);
  cwt_state_t       state;
  logic [IDX_W-1:0] sel_q;
  logic [PER_W-1:0] per_eff;
  logic [PER_W-1:0] thr;
  logic [ENT_W-1:0] entry_q;
  logic [MIN_W-1:0] min_q;
  logic             en_q;
  logic             hit;
  logic             per_we;
  logic             cnt_clr;
  logic             cnt_en;
  logic [MIN_W-1:0] min_wr;

  assign per_we = cfg_we && (cfg_kind == WK_PERIOD) && (cfg_idx < IDX_W'(N_PER));
  assign min_wr = (cfg_data[MIN_W-1:0] < MIN_W'(MIN_FLOOR)) ? MIN_W'(MIN_FLOOR)
                                                             : cfg_data[MIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= '0;
      min_q   <= MIN_W'(MIN_FLOOR);
      en_q    <= 1'b0;
    end else begin
      if (launch && (state != ST_RUN)) en_q <= 1'b1;
      if (cfg_we) begin
        unique case (cfg_kind)
          WK_ENTRY:  entry_q <= cfg_data[ENT_W-1:0];
          WK_MINSLP: min_q   <= min_wr;
          WK_CTRL:   en_q    <= cfg_data[0];
          default:   ;
        endcase
      end
    end
  end

  cwt_period_bank #(.N_PER(N_PER), .PER_W(PER_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (per_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .rd_idx  (sel_q),
    .rd_eff  (per_eff)
  );

  assign thr     = (per_eff < PER_W'(min_q)) ? PER_W'(min_q) : per_eff;
  assign cnt_en  = (state == ST_SLEEP) && en_q;
  assign cnt_clr = (state != ST_SLEEP) || launch;

  cwt_tick_counter #(.PER_W(PER_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clr),
    .cnt_en (cnt_en),
    .tick   (slow_tick),
    .thr    (thr),
    .hit    (hit)
  );

  cwt_wake_fsm #(.N_PER(N_PER), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .en_q      (en_q),
    .hit       (hit),
    .stop      (core_halt || core_illegal),
    .slp_valid (slp_valid),
    .slp_idx   (slp_idx),
    .entry_q   (entry_q),
    .state     (state),
    .sel_q     (sel_q),
    .pwr       (core_pwr),
    .go        (core_go),
    .entry_out (core_entry)
  );
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int ENT_W     = 11,
  parameter int MIN_W     = 8,
  parameter int MIN_FLOOR = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             core_pwr,
  input logic             core_go,
  input logic [ENT_W-1:0] core_entry,
  input logic             core_halt,
  input logic             core_illegal,
  input logic             en_q,
  input logic [MIN_W-1:0] min_q
);
  a_r4_go_single: assert property (@(posedge clk) disable iff (rst)
    core_go |=> !core_go);

  a_r4_go_with_power: assert property (@(posedge clk) disable iff (rst)
    $rose(core_pwr) |-> core_go);

  a_r5_stop_unpowers: assert property (@(posedge clk) disable iff (rst)
    (core_pwr && (core_halt || core_illegal)) |=> !core_pwr);

  a_r10_entry_held: assert property (@(posedge clk) disable iff (rst)
    (core_pwr && !core_go) |-> $stable(core_entry));

  a_r8_no_wake_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !core_go);

  a_r6_min_floor: assert property (@(posedge clk) disable iff (rst)
    min_q >= MIN_W'(MIN_FLOOR));
endmodule

bind cop_wake_timer cwt_checker #(.ENT_W(ENT_W), .MIN_W(MIN_W), .MIN_FLOOR(MIN_FLOOR)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .core_pwr     (core_pwr),
  .core_go      (core_go),
  .core_entry   (core_entry),
  .core_halt    (core_halt),
  .core_illegal (core_illegal),
  .en_q         (en_q),
  .min_q        (min_q)
);

// File: tb/sim_cop_wake_timer.sv
module sim_cop_wake_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [2:0]  cfg_idx = '0;
  logic [23:0] cfg_data = '0;
  logic        launch = 1'b0;
  logic        slp_valid = 1'b0;
  logic [2:0]  slp_idx = '0;
  logic        core_halt = 1'b0;
  logic        core_illegal = 1'b0;
  logic        core_pwr;
  logic        core_go;
  logic [10:0] core_entry;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cop_wake_timer u0 (
    .clk, .rst, .slow_tick, .cfg_we, .cfg_kind, .cfg_idx, .cfg_data,
    .launch, .slp_valid, .slp_idx, .core_halt, .core_illegal,
    .core_pwr, .core_go, .core_entry
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // period, min sleep written, expected wake tick
  localparam logic [63:0] VEC [8] = '{
    {24'd5,   8'd2,  32'd5},
    {24'd1,   8'd2,  32'd2},
    {24'd0,   8'd2,  32'd2},
    {24'd3,   8'd10, 32'd10},
    {24'd300, 8'd2,  32'd300},
    {24'd7,   8'd0,  32'd7},
    {24'd0,   8'd0,  32'd2},
    {24'd1,   8'd3,  32'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] i, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_launch();
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
  endtask

  task automatic wait_wake(input int maxt, output int n);
    n = -1;
    for (int k = 1; k <= maxt; k++) begin
      tick_once();
      if (core_pwr) begin n = k; break; end
    end
  endtask

  task automatic stop_core(input bit ill);
    @(negedge clk);
    if (ill) core_illegal = 1'b1; else core_halt = 1'b1;
    @(negedge clk);
    core_illegal = 1'b0; core_halt = 1'b0;
  endtask

  task automatic sleep_cmd(input logic [2:0] i);
    @(negedge clk); slp_valid = 1'b1; slp_idx = i;
    @(negedge clk); slp_valid = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pwr after reset", int'(core_pwr), 0);
    chk("R1 go after reset", int'(core_go), 0);
    chk("R1 entry after reset", int'(core_entry), 0);
    wait_wake(10, n);
    chk("R1 no wake before launch", n, -1);

    // vector table: R2 R4 R6 R9
    foreach (VEC[v]) begin
      wr(2'd0, 3'd0, VEC[v][63:40]);
      wr(2'd2, 3'd0, {16'd0, VEC[v][39:32]});
      pulse_launch();
      wait_wake(int'(VEC[v][31:0]) + 5, n);
      chk("R2/R4/R6/R9 wake tick", n, int'(VEC[v][31:0]));
      stop_core(1'b0);
      chk("R5 pwr off after halt", int'(core_pwr), 0);
    end

    // entry capture and sleep select: R3 R4 R10
    wr(2'd2, 3'd0, 24'd2);
    wr(2'd1, 3'd0, 24'h155);
    wr(2'd0, 3'd0, 24'd7);
    wr(2'd0, 3'd2, 24'd4);
    pulse_launch();
    wait_wake(20, n);
    chk("R2 launch uses period 0", n, 7);
    chk("R4 go with wake", int'(core_go), 1);
    chk("R10 entry at wake", int'(core_entry), 'h155);
    @(negedge clk);
    chk("R4 go single cycle", int'(core_go), 0);
    wr(2'd1, 3'd0, 24'h2AA);
    chk("R10 entry unchanged during run", int'(core_entry), 'h155);
    sleep_cmd(3'd2);
    sleep_cmd(3'd6);
    stop_core(1'b0);
    wait_wake(20, n);
    chk("R3 selected period 2, index 6 ignored", n, 4);
    chk("R10 new entry at next wake", int'(core_entry), 'h2AA);

    // illegal instruction: R5
    stop_core(1'b1);
    chk("R5 pwr off after illegal", int'(core_pwr), 0);
    wait_wake(20, n);
    chk("R5 count restarts after illegal", n, 4);

    // rejected period writes: R7
    wr(2'd0, 3'd5, 24'd1);
    wr(2'd0, 3'd7, 24'd1);
    stop_core(1'b0);
    wait_wake(20, n);
    chk("R7 out-of-range write rejected", n, 4);

    // disable: R8
    stop_core(1'b0);
    wr(2'd3, 3'd0, 24'd0);
    wait_wake(20, n);
    chk("R8 no wake when disabled", n, -1);
    pulse_launch();
    wait_wake(20, n);
    chk("R8 launch re-enables with period 0", n, 7);
    wr(2'd3, 3'd0, 24'd0);
    stop_core(1'b0);
    wait_wake(20, n);
    chk("R8 disabled during run stays idle", n, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule